// File: doc/BRIEF.md
# Packet Buffer Slot Manager

This block decides which of a small set of packet buffer slots is owned by whom. The host issues 3-bit commands to claim a slot for transmission, hand a slot to the transmit side, release slots and drain the receive side. The block keeps three queues of slot numbers: slots waiting to be transmitted, slots whose transmission has finished, and slots holding received frames. A first-free search serves both host allocation and the receive path. The data storage and the frame engines are outside the block. A one-wire "transmit finished" strobe and a one-wire "frame arrived" strobe stand in for them.

The block also keeps an 8-bit interrupt status register and an 8-bit mask, and it drives a level interrupt. It reports the heads of the completed and receive queues, the allocation result and a memory summary as plain output words. Only one state-changing event is taken per clock. A host command beats an interrupt acknowledge, which beats a transmit completion, which beats a receive arrival. A losing event in that cycle has no effect.

Top module: `pkt_slot_mgr`

## Requirements
- R1: The command code is `cmd_byte[7:5]` and bits 4:0 are ignored. The codes are: 0 nothing, 1 allocate, 2 reset unit, 3 pop receive queue, 4 pop receive queue and free its slot, 5 free slot `cur_pkt`, 6 queue slot `cur_pkt` for transmit, 7 clear both transmit queues.
- R2: Allocate claims the lowest-numbered free slot. On success `alloc_result` holds the slot number and status bit 3 (0x08) is set. When no slot is free, `alloc_result` reads 0x90 and bit 3 is cleared.
- R3: Status bits are receive 0x01, transmit-done 0x02, transmit-idle 0x04, allocated 0x08, overrun 0x10, protocol 0x20 and line 0x80. An acknowledge clears exactly the bits set in both `ack_clr` and 0xDE, so bits 0x01 and 0x20 survive an acknowledge.
- R4: An acknowledge loads `irq_mask` from `ack_mask` and the mask changes at no other time. If `ack_clr[1]` is set, the acknowledge also pops the completed queue. If that queue is empty, the mask is left unchanged.
- R5: Bit 0x04 is set in every cycle in which the transmit-waiting queue is empty, and bit 0x02 in every cycle in which the completed queue is not empty. `irq` is high exactly when `irq_mask & irq_status` is non-zero.
- R6: After a receive pop (code 3 or 4), bit 0x01 is set if entries remain in the receive queue and cleared if none remain. Code 4 also frees the slot that was at the head.
- R7: `fifo_heads[7:0]` is the head of the completed queue and `fifo_heads[15:8]` is the head of the receive queue. An empty queue reads 0x80.
- R8: `tx_req` is high while the transmit-waiting queue is non-empty, and `tx_slot` is its head. On `tx_done` the head is removed. The slot is freed if `autorel` is high and otherwise goes onto the completed queue.
- R9: `mem_info[7:0]` is the slot count and `mem_info[15:8]` is the slot count minus the receive queue length.
- R10: Reset unit (code 2) frees every slot, empties all three queues and sets `alloc_result` to 0x90.
- R11: After `rst_n` the status is 0x04, the mask is 0x00, `alloc_result` is 0x90, all queues are empty and all slots are free.
- R12: `rx_push` claims the lowest free slot, appends it to the receive queue and sets bit 0x01. With no free slot, the frame is dropped and nothing changes.
- R13: Per cycle only one of `cmd_valid`, `ack_we`, `tx_done`, `rx_push` takes effect, in that priority order.
- R14: Code 5 frees slot `cur_pkt` modulo the slot count. Code 6 appends that slot to the transmit-waiting queue and is ignored when the queue is full. Code 7 empties the transmit-waiting and completed queues.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Host command strobe |
| cmd_byte | input | 8 | Command byte, code in bits 7:5 |
| pnum_we | input | 1 | Write strobe for the packet-number register |
| pnum_wdata | input | 8 | New packet number |
| ack_we | input | 1 | Interrupt acknowledge strobe |
| ack_clr | input | 8 | Status bits to clear |
| ack_mask | input | 8 | New interrupt mask |
| autorel | input | 1 | Free slots on transmit completion |
| tx_done | input | 1 | Transmit side finished the head slot |
| rx_push | input | 1 | A received frame needs a slot |
| tx_req | output | 1 | Transmit-waiting queue non-empty |
| tx_slot | output | 8 | Head of transmit-waiting queue |
| cur_pkt | output | 8 | Packet-number register |
| alloc_result | output | 8 | Last allocation result or 0x90 |
| irq_status | output | 8 | Interrupt status |
| irq_mask | output | 8 | Interrupt mask |
| irq | output | 1 | Level interrupt |
| fifo_heads | output | 16 | Receive head (high), completed head (low) |
| mem_info | output | 16 | Free-of-receive count (high), slot count (low) |

## Verification
A slot ownership bit that is wrong stays hidden until the next allocation. That allocation then returns the wrong number or 0x90 one cycle after the command. The reference model is compared every clock, so the fault is caught at that allocation and not at some later readback. A wrong queue entry or count shows at once in `fifo_heads`, `tx_slot` or `mem_info`. A status bit that is wrongly sticky or wrongly cleared appears on `irq_status` and `irq` in the cycle after the event.

// File: rtl/pkt_slot_pkg.sv
package pkt_slot_pkg;

   typedef enum logic [2:0] {
      OP_NOP       = 3'd0,
      OP_ALLOC     = 3'd1,
      OP_RESET     = 3'd2,
      OP_RXPOP     = 3'd3,
      OP_RXPOP_REL = 3'd4,
      OP_FREE      = 3'd5,
      OP_TXQ       = 3'd6,
      OP_TXCLR     = 3'd7
   } mmu_op_e;

   localparam logic [7:0] RES_FAIL  = 8'h90;
   localparam logic [7:0] HEAD_NONE = 8'h80;
   localparam logic [7:0] ACK_MASK  = 8'hDE;
   localparam logic [7:0] STAT_INIT = 8'h04;

   localparam int BIT_RX    = 0;
   localparam int BIT_TX    = 1;
   localparam int BIT_TXE   = 2;
   localparam int BIT_ALLOC = 3;

endpackage

// File: rtl/slot_fifo.sv
module slot_fifo #(
   parameter int DEPTH = 4,
   parameter int W     = 2,
   localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
   localparam int CW   = $clog2(DEPTH + 1)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr,
   input  logic          push,
   input  logic          pop,
   input  logic [W-1:0]  din,
   output logic [W-1:0]  head,
   output logic [CW-1:0] count,
   output logic          empty,
   output logic          full,
   output logic          empty_nx
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("slot_fifo: DEPTH must be at least 2");
      end
   endgenerate

   logic [PW-1:0] wr_ptr, rd_ptr;
   logic [CW-1:0] count_nx;
   logic          do_push, do_pop;
   logic [W-1:0]  mem [DEPTH];

   function automatic logic [PW-1:0] ptr_inc(input logic [PW-1:0] p);
      return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
   endfunction

   assign empty   = (count == '0);
   assign full    = (count == CW'(DEPTH));
   assign do_pop  = pop && !empty;
   assign do_push = push && (!full || do_pop);
   assign head    = mem[rd_ptr];

   always_comb begin
      if (clr) count_nx = '0;
      else     count_nx = count + CW'(do_push) - CW'(do_pop);
   end
   assign empty_nx = (count_nx == '0);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else if (clr) begin
         wr_ptr <= '0;
         rd_ptr <= '0;
         count  <= '0;
      end else begin
         if (do_push) wr_ptr <= ptr_inc(wr_ptr);
         if (do_pop)  rd_ptr <= ptr_inc(rd_ptr);
         count <= count_nx;
      end
   end

   for (genvar g = 0; g < DEPTH; g++) begin : g_entry
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            mem[g] <= '0;
         else if (do_push && !clr && wr_ptr == PW'(g))
            mem[g] <= din;
      end
   end

endmodule

// File: rtl/slot_alloc.sv
module slot_alloc #(
   parameter int NSLOT = 4,
   localparam int SW   = $clog2(NSLOT)
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_all,
   input  logic          grab,
   input  logic          rel_en,
   input  logic [SW-1:0] rel_idx,
   output logic          found,
   output logic [SW-1:0] pick
);

   logic [NSLOT-1:0] busy;

   always_comb begin
      found = 1'b0;
      pick  = '0;
      for (int i = NSLOT - 1; i >= 0; i--) begin
         if (!busy[i]) begin
            found = 1'b1;
            pick  = SW'(i);
         end
      end
   end

   for (genvar g = 0; g < NSLOT; g++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            busy[g] <= 1'b0;
         else if (clr_all)
            busy[g] <= 1'b0;
         else if (grab && found && pick == SW'(g))
            busy[g] <= 1'b1;
         else if (rel_en && rel_idx == SW'(g))
            busy[g] <= 1'b0;
      end
   end

endmodule

// File: rtl/slot_irq.sv
module slot_irq
   import pkt_slot_pkg::*;
(
   input  logic       clk,
   input  logic       rst_n,
   input  logic       ack_en,
   input  logic [7:0] ack_bits,
   input  logic       mask_en,
   input  logic [7:0] mask_val,
   input  logic       set_rx,
   input  logic       clr_rx,
   input  logic       set_alloc,
   input  logic       clr_alloc,
   input  logic       txe_cond,
   input  logic       tx_cond,
   output logic [7:0] status,
   output logic [7:0] mask,
   output logic       irq
);

   logic [7:0] status_nx;

   always_comb begin
      status_nx = status;
      if (clr_alloc) status_nx[BIT_ALLOC] = 1'b0;
      if (set_alloc) status_nx[BIT_ALLOC] = 1'b1;
      if (clr_rx)    status_nx[BIT_RX]    = 1'b0;
      if (set_rx)    status_nx[BIT_RX]    = 1'b1;
      if (ack_en)    status_nx = status_nx & ~(ack_bits & ACK_MASK);
      if (txe_cond)  status_nx[BIT_TXE]   = 1'b1;
      if (tx_cond)   status_nx[BIT_TX]    = 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         status <= STAT_INIT;
         mask   <= '0;
      end else begin
         status <= status_nx;
         if (mask_en) mask <= mask_val;
      end
   end

   assign irq = |(status & mask);

endmodule

// File: rtl/pkt_slot_mgr.sv
module pkt_slot_mgr
   import pkt_slot_pkg::*;
#(
   parameter int NSLOT = 4,
   localparam int SW   = $clog2(NSLOT),
   localparam int CW   = $clog2(NSLOT + 1)
) (
   input  logic        clk,
   input  logic        rst_n,
   input  logic        cmd_valid,
   input  logic [7:0]  cmd_byte,
   input  logic        pnum_we,
   input  logic [7:0]  pnum_wdata,
   input  logic        ack_we,
   input  logic [7:0]  ack_clr,
   input  logic [7:0]  ack_mask,
   input  logic        autorel,
   input  logic        tx_done,
   input  logic        rx_push,
   output logic        tx_req,
   output logic [7:0]  tx_slot,
   output logic [7:0]  cur_pkt,
   output logic [7:0]  alloc_result,
   output logic [7:0]  irq_status,
   output logic [7:0]  irq_mask,
   output logic        irq,
   output logic [15:0] fifo_heads,
   output logic [15:0] mem_info
);

   generate
      if (NSLOT < 2 || NSLOT > 64) begin : g_bad_nslot
         $error("pkt_slot_mgr: NSLOT must lie in 2..64");
      end
   endgenerate

   // queue controls
   logic          pend_push, pend_pop, pend_clr;
   logic          done_push, done_pop, done_clr;
   logic          rx_push_q, rx_pop, rx_clr;
   logic [SW-1:0] pend_din, done_din, rx_din;
   logic [SW-1:0] pend_head, done_head, rx_head;
   logic [CW-1:0] pend_cnt, done_cnt, rx_cnt;
   logic          pend_empty, done_empty, rx_empty;
   logic          pend_full, done_full, rx_full;
   logic          pend_empty_nx, done_empty_nx, rx_empty_nx;

   // allocator controls
   logic          clr_all, grab, rel_en, found;
   logic [SW-1:0] rel_idx, pick;

   // interrupt controls
   logic          ack_en, mask_en, set_rx, clr_rx, set_alloc, clr_alloc;

   // result register
   logic          res_we;
   logic [7:0]    res_val;

   mmu_op_e       op;
   logic          take_ack, take_tx, take_rx;
   logic          unused_bits;

   assign op          = mmu_op_e'(cmd_byte[7:5]);
   assign unused_bits = ^{cmd_byte[4:0], pend_cnt, done_cnt, pend_full, done_full, rx_full,
                          pend_empty_nx, rx_empty};
   assign take_ack    = !cmd_valid && ack_we;
   assign take_tx     = !cmd_valid && !ack_we && tx_done;
   assign take_rx     = !cmd_valid && !ack_we && !tx_done && rx_push;

   always_comb begin
      pend_push = 1'b0; pend_pop = 1'b0; pend_clr = 1'b0;
      done_push = 1'b0; done_pop = 1'b0; done_clr = 1'b0;
      rx_push_q = 1'b0; rx_pop   = 1'b0; rx_clr   = 1'b0;
      pend_din  = cur_pkt[SW-1:0];
      done_din  = pend_head;
      rx_din    = pick;
      clr_all   = 1'b0; grab = 1'b0; rel_en = 1'b0; rel_idx = '0;
      ack_en    = 1'b0; mask_en = 1'b0;
      set_rx    = 1'b0; clr_rx = 1'b0; set_alloc = 1'b0; clr_alloc = 1'b0;
      res_we    = 1'b0; res_val = RES_FAIL;

      if (cmd_valid) begin
         unique case (op)
            OP_NOP: ;
            OP_ALLOC: begin
               grab      = 1'b1;
               res_we    = 1'b1;
               res_val   = found ? 8'(pick) : RES_FAIL;
               clr_alloc = 1'b1;
               set_alloc = found;
            end
            OP_RESET: begin
               clr_all  = 1'b1;
               pend_clr = 1'b1;
               done_clr = 1'b1;
               rx_clr   = 1'b1;
               res_we   = 1'b1;
               res_val  = RES_FAIL;
            end
            OP_RXPOP: begin
               rx_pop = 1'b1;
               set_rx = !rx_empty_nx;
               clr_rx = rx_empty_nx;
            end
            OP_RXPOP_REL: begin
               rx_pop  = 1'b1;
               rel_en  = !rx_empty;
               rel_idx = rx_head;
               set_rx  = !rx_empty_nx;
               clr_rx  = rx_empty_nx;
            end
            OP_FREE: begin
               rel_en  = 1'b1;
               rel_idx = cur_pkt[SW-1:0];
            end
            OP_TXQ: begin
               pend_push = 1'b1;
            end
            OP_TXCLR: begin
               pend_clr = 1'b1;
               done_clr = 1'b1;
            end
            default: ;
         endcase
      end else if (take_ack) begin
         ack_en = 1'b1;
         if (ack_clr[BIT_TX]) begin
            done_pop = !done_empty;
            mask_en  = !done_empty;
         end else begin
            mask_en = 1'b1;
         end
      end else if (take_tx) begin
         if (!pend_empty) begin
            pend_pop = 1'b1;
            if (autorel) begin
               rel_en  = 1'b1;
               rel_idx = pend_head;
            end else begin
               done_push = 1'b1;
            end
         end
      end else if (take_rx) begin
         grab      = 1'b1;
         rx_push_q = found;
         set_rx    = found;
      end
   end

   slot_fifo #(.DEPTH(NSLOT), .W(SW)) u_pend (
      .clk(clk), .rst_n(rst_n), .clr(pend_clr), .push(pend_push), .pop(pend_pop),
      .din(pend_din), .head(pend_head), .count(pend_cnt), .empty(pend_empty),
      .full(pend_full), .empty_nx(pend_empty_nx)
   );

   slot_fifo #(.DEPTH(NSLOT), .W(SW)) u_done (
      .clk(clk), .rst_n(rst_n), .clr(done_clr), .push(done_push), .pop(done_pop),
      .din(done_din), .head(done_head), .count(done_cnt), .empty(done_empty),
      .full(done_full), .empty_nx(done_empty_nx)
   );

   slot_fifo #(.DEPTH(NSLOT), .W(SW)) u_rxq (
      .clk(clk), .rst_n(rst_n), .clr(rx_clr), .push(rx_push_q), .pop(rx_pop),
      .din(rx_din), .head(rx_head), .count(rx_cnt), .empty(rx_empty),
      .full(rx_full), .empty_nx(rx_empty_nx)
   );

   slot_alloc #(.NSLOT(NSLOT)) u_alloc (
      .clk(clk), .rst_n(rst_n), .clr_all(clr_all), .grab(grab),
      .rel_en(rel_en), .rel_idx(rel_idx), .found(found), .pick(pick)
   );

   slot_irq u_irq (
      .clk(clk), .rst_n(rst_n), .ack_en(ack_en), .ack_bits(ack_clr),
      .mask_en(mask_en), .mask_val(ack_mask), .set_rx(set_rx), .clr_rx(clr_rx),
      .set_alloc(set_alloc), .clr_alloc(clr_alloc),
      .txe_cond(pend_empty_nx), .tx_cond(!done_empty_nx),
      .status(irq_status), .mask(irq_mask), .irq(irq)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         alloc_result <= RES_FAIL;
         cur_pkt      <= '0;
      end else begin
         if (res_we)  alloc_result <= res_val;
         if (pnum_we) cur_pkt      <= pnum_wdata;
      end
   end

   assign tx_req     = !pend_empty;
   assign tx_slot    = 8'(pend_head);
   assign fifo_heads = {rx_empty ? HEAD_NONE : 8'(rx_head),
                        done_empty ? HEAD_NONE : 8'(done_head)};
   assign mem_info   = {8'(NSLOT) - 8'(rx_cnt), 8'(NSLOT)};

endmodule

// File: rtl/pkt_slot_mgr_chk.sv
module pkt_slot_mgr_chk #(
   parameter int NSLOT = 4
) (
   input logic        clk,
   input logic        rst_n,
   input logic        cmd_valid,
   input logic [7:0]  cmd_byte,
   input logic        ack_we,
   input logic        tx_req,
   input logic [7:0]  alloc_result,
   input logic [7:0]  irq_status,
   input logic [7:0]  irq_mask,
   input logic [15:0] fifo_heads,
   input logic [15:0] mem_info
);

   AST_TXE_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
      !tx_req |-> irq_status[2]); // R5
   AST_TX_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_heads[7:0] != 8'h80) |-> irq_status[1]); // R5
   AST_RX_WHEN_QUEUED: assert property (@(posedge clk) disable iff (!rst_n)
      (fifo_heads[15:8] != 8'h80) |-> irq_status[0]); // R12
   AST_ALLOC_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_byte[7:5] == 3'd1) |=> ((alloc_result == 8'h90) == !irq_status[3])); // R2
   AST_MEMINFO_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_info[15:8] <= mem_info[7:0]) && (mem_info[7:0] == 8'(NSLOT))); // R9
   AST_UNIT_RESET: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_valid && cmd_byte[7:5] == 3'd2) |=> (fifo_heads == 16'h8080 && !tx_req && alloc_result == 8'h90)); // R10
   AST_MASK_ONLY_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      !ack_we |=> $stable(irq_mask)); // R4
   AST_CMD_BEATS_ACK: assert property (@(posedge clk) disable iff (!rst_n)
      cmd_valid |=> $stable(irq_mask)); // R13

endmodule

bind pkt_slot_mgr pkt_slot_mgr_chk #(.NSLOT(NSLOT)) u_chk (
   .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
   .ack_we(ack_we), .tx_req(tx_req), .alloc_result(alloc_result),
   .irq_status(irq_status), .irq_mask(irq_mask), .fifo_heads(fifo_heads),
   .mem_info(mem_info)
);

// File: tb/sim_pkt_slot_mgr.sv
`timescale 1ns/1ps
module sim_pkt_slot_mgr;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cmd_valid = 0, pnum_we = 0, ack_we = 0, autorel = 0, tx_done = 0, rx_push = 0;
   logic [7:0]  cmd_byte = 0, pnum_wdata = 0, ack_clr = 0, ack_mask = 0;
   logic        tx_req, irq;
   logic [7:0]  tx_slot, cur_pkt, alloc_result, irq_status, irq_mask;
   logic [15:0] fifo_heads, mem_info;

   int tests = 0, fails = 0;
   bit done_flag = 0;

   always #10 clk = ~clk;

   pkt_slot_mgr #(.NSLOT(4)) u0 (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
      .pnum_we(pnum_we), .pnum_wdata(pnum_wdata), .ack_we(ack_we), .ack_clr(ack_clr),
      .ack_mask(ack_mask), .autorel(autorel), .tx_done(tx_done), .rx_push(rx_push),
      .tx_req(tx_req), .tx_slot(tx_slot), .cur_pkt(cur_pkt), .alloc_result(alloc_result),
      .irq_status(irq_status), .irq_mask(irq_mask), .irq(irq),
      .fifo_heads(fifo_heads), .mem_info(mem_info)
   );

   // ---------------- reference model ----------------
   int pend[$], done[$], rxq[$];
   bit busy[4];
   logic [7:0] st, mk, res, pn;

   always @(posedge clk or negedge rst_n) begin
      int k, pk;
      bit fnd;
      if (!rst_n) begin
         pend.delete(); done.delete(); rxq.delete();
         foreach (busy[i]) busy[i] = 0;
         st = 8'h04; mk = 8'h00; res = 8'h90; pn = 8'h00;
      end else begin
         fnd = 0; pk = 0;
         for (int i = 3; i >= 0; i--) if (!busy[i]) begin fnd = 1; pk = i; end
         if (cmd_valid) begin
            case (cmd_byte[7:5])
               3'd1: begin
                  res = 8'h90; st[3] = 0;
                  if (fnd) begin busy[pk] = 1; res = 8'(pk); st[3] = 1; end
               end
               3'd2: begin
                  foreach (busy[i]) busy[i] = 0;
                  pend.delete(); done.delete(); rxq.delete(); res = 8'h90;
               end
               3'd3: begin
                  if (rxq.size() != 0) void'(rxq.pop_front());
                  st[0] = (rxq.size() != 0);
               end
               3'd4: begin
                  if (rxq.size() != 0) begin busy[rxq[0]] = 0; void'(rxq.pop_front()); end
                  st[0] = (rxq.size() != 0);
               end
               3'd5: busy[pn % 4] = 0;
               3'd6: if (pend.size() < 4) pend.push_back(int'(pn % 4));
               3'd7: begin pend.delete(); done.delete(); end
               default: ;
            endcase
         end else if (ack_we) begin
            st = st & ~(ack_clr & 8'hDE);
            if (ack_clr[1]) begin
               if (done.size() != 0) begin void'(done.pop_front()); mk = ack_mask; end
            end else mk = ack_mask;
         end else if (tx_done) begin
            if (pend.size() != 0) begin
               k = pend.pop_front();
               if (autorel) busy[k] = 0;
               else if (done.size() < 4) done.push_back(k);
            end
         end else if (rx_push) begin
            if (fnd) begin
               busy[pk] = 1;
               if (rxq.size() < 4) rxq.push_back(pk);
               st[0] = 1;
            end
         end
         if (pnum_we) pn = pnum_wdata;
         if (pend.size() == 0) st[2] = 1;
         if (done.size() != 0) st[1] = 1;
      end
   end

   task automatic chk(input string req, input string what, input int got, input int exp);
      tests++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h", req, what, got, exp);
      end
   endtask

   // every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done_flag) begin
         chk("R2",  "alloc_result", alloc_result, res);
         chk("R5",  "irq_status", irq_status, st);
         chk("R4",  "irq_mask", irq_mask, mk);
         chk("R5",  "irq", irq, ((st & mk) != 0));
         chk("R7",  "fifo_heads", fifo_heads,
             {(rxq.size() != 0) ? 8'(rxq[0]) : 8'h80, (done.size() != 0) ? 8'(done[0]) : 8'h80});
         chk("R9",  "mem_info", mem_info, {8'(4 - rxq.size()), 8'h04});
         chk("R8",  "tx_req", tx_req, (pend.size() != 0));
         if (pend.size() != 0) chk("R8", "tx_slot", tx_slot, pend[0]);
         chk("R14", "cur_pkt", cur_pkt, pn);
      end
   end

   // ---------------- stimulus tasks ----------------
   task automatic cmd(input logic [7:0] b);
      cmd_byte = b; cmd_valid = 1; @(negedge clk); cmd_valid = 0;
   endtask
   task automatic setp(input logic [7:0] v);
      pnum_wdata = v; pnum_we = 1; @(negedge clk); pnum_we = 0;
   endtask
   task automatic ack(input logic [7:0] c, input logic [7:0] m);
      ack_clr = c; ack_mask = m; ack_we = 1; @(negedge clk); ack_we = 0;
   endtask
   task automatic txd();
      tx_done = 1; @(negedge clk); tx_done = 0;
   endtask
   task automatic rxp();
      rx_push = 1; @(negedge clk); rx_push = 0;
   endtask

   initial begin
      #4_000_000;
      if (!done_flag) begin
         done_flag = 1;
         tests++; fails++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R11 reset state
      chk("R11", "status", irq_status, 8'h04);
      chk("R11", "mask", irq_mask, 8'h00);
      chk("R11", "result", alloc_result, 8'h90);
      chk("R11", "heads", fifo_heads, 16'h8080);

      // R1 low bits ignored; R2 lowest-first
      cmd(8'h3F); chk("R1", "alloc with junk low bits", alloc_result, 8'h00);
      cmd(8'h1F); chk("R1", "code 0 no effect", alloc_result, 8'h00);
      cmd(8'h20); cmd(8'h20); cmd(8'h20);
      chk("R2", "fourth slot", alloc_result, 8'h03);
      cmd(8'h20);
      chk("R2", "full gives fail", alloc_result, 8'h90);
      chk("R2", "alloc bit cleared", irq_status[3], 1'b0);

      // R14 free slot 2 then realloc
      setp(8'h02); cmd(8'hA0); cmd(8'h20);
      chk("R14", "freed slot reused", alloc_result, 8'h02);
      chk("R2", "alloc bit set", irq_status[3], 1'b1);

      // R8 transmit path without autorelease
      setp(8'h01); cmd(8'hC0);
      chk("R8", "tx_slot", tx_slot, 8'h01);
      ack(8'h04, 8'h00);
      chk("R5", "idle bit cleared while busy", irq_status[2], 1'b0);
      txd();
      chk("R8", "completed head", fifo_heads[7:0], 8'h01);
      chk("R5", "tx bit set", irq_status[1], 1'b1);
      chk("R5", "idle bit back", irq_status[2], 1'b1);
      ack(8'h02, 8'h06);
      chk("R4", "pop completed", fifo_heads[7:0], 8'h80);
      chk("R4", "mask loaded", irq_mask, 8'h06);
      chk("R5", "irq level", irq, 1'b1);
      ack(8'h02, 8'hFF);
      chk("R4", "mask kept on empty pop", irq_mask, 8'h06);
      ack(8'hFF, 8'h06);
      chk("R3", "clear all writable", irq_status, 8'h04);

      // R12 receive path
      setp(8'h03); cmd(8'hA0); rxp();
      chk("R12", "rx head", fifo_heads[15:8], 8'h03);
      chk("R9", "mem info", mem_info, 16'h0304);
      ack(8'h01, 8'h06);
      chk("R3", "rx bit not ackable", irq_status[0], 1'b1);
      rxp();
      chk("R12", "drop when full", mem_info, 16'h0304);
      setp(8'h00); cmd(8'hA0); rxp();
      chk("R12", "second rx", mem_info, 16'h0204);

      // R6 pops
      cmd(8'h60);
      chk("R6", "head after pop", fifo_heads[15:8], 8'h00);
      chk("R6", "rx bit stays", irq_status[0], 1'b1);
      cmd(8'h80);
      chk("R6", "queue empty", fifo_heads[15:8], 8'h80);
      chk("R6", "rx bit cleared", irq_status[0], 1'b0);
      cmd(8'h20);
      chk("R6", "slot freed by code 4", alloc_result, 8'h00);

      // R8 autorelease
      autorel = 1;
      setp(8'h02); cmd(8'hC0); txd();
      chk("R8", "autorel no completed entry", fifo_heads[7:0], 8'h80);
      cmd(8'h20);
      chk("R8", "autorel frees slot", alloc_result, 8'h02);
      autorel = 0;

      // R13 command beats transmit completion
      setp(8'h01); cmd(8'hC0);
      cmd_byte = 8'hE0; cmd_valid = 1; tx_done = 1; @(negedge clk);
      cmd_valid = 0; tx_done = 0;
      chk("R13", "tx_done lost to command", fifo_heads[7:0], 8'h80);
      chk("R14", "code 7 empties pending", tx_req, 1'b0);

      // R10 reset unit
      rxp();
      cmd(8'h40);
      chk("R10", "heads", fifo_heads, 16'h8080);
      chk("R10", "result", alloc_result, 8'h90);
      cmd(8'h20);
      chk("R10", "all free", alloc_result, 8'h00);

      // random traffic against the model
      for (int n = 0; n < 4000; n++) begin
         int r;
         r = $urandom_range(0, 99);
         cmd_valid  = (r < 30);
         cmd_byte   = 8'($urandom);
         pnum_we    = ($urandom_range(0, 3) == 0);
         pnum_wdata = 8'($urandom);
         ack_we     = ($urandom_range(0, 4) == 0);
         ack_clr    = 8'($urandom);
         ack_mask   = 8'($urandom);
         tx_done    = ($urandom_range(0, 3) == 0);
         rx_push    = ($urandom_range(0, 2) == 0);
         autorel    = ($urandom_range(0, 3) == 0);
         @(negedge clk);
      end
      cmd_valid = 0; pnum_we = 0; ack_we = 0; tx_done = 0; rx_push = 0;
      @(negedge clk);

      if (!done_flag) begin
         done_flag = 1;
         $display("[TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

endmodule